// File: doc/BRIEF.md
# Multidrop Address-Filtering UART Receiver

This block turns an asynchronous serial input into characters and pushes them, with per-character error tags, into an external receive FIFO through a one-byte push port. The character format is set by static inputs: 7, 8 or 9 data bits, an optional parity slot and one or two stop bits. The bit period is a programmable number of clock cycles.

On top of plain reception the block can filter a multidrop bus. A ninth or parity-position bit of 1 marks an address byte. The address is compared with two programmable characters, and the result opens or closes a receive gate. Address bytes never reach the FIFO. One variant also drives a hold output that keeps a line driver enabled after a match. In software flow-control mode the same two characters are treated as resume and pause codes for the local transmitter. In half-duplex mode the line is ignored while the local transmitter is busy. Break, framing, parity and overrun events are kept as sticky flags that clear on read, and a live break bit sits beside them.

Top module: `mdrop_uart_rx`

## Requirements
- R1: A frame is a low start bit, then `fmt_len_i` data bits LSB first (00 = 7, 01 = 8, 10 = 9), then a parity slot when `par_mode_i` is non-zero and the length is not 9, then one stop bit, or two when `two_stop_i` = 1. Each slot lasts `bit_div_i` clocks. In a mode without filtering, a received 7- or 8-bit character is pushed once with the value on `push_data_o`.
- R2: A start bit must still read low at its mid-point. A shorter low pulse returns the receiver to idle and pushes nothing.
- R3: In `flow_mode_i` 011 or 100 a frame whose ninth slot is 1 is an address. The ninth slot is data bit 8 in 9-bit mode and the parity slot otherwise. An address equal to `match_on_i` or `match_off_i` opens the gate (`rx_open_o` = 1), and any other address closes it. The gate is closed after reset. Address bytes are never pushed, and data bytes are pushed only while the gate is open.
- R4: In `flow_mode_i` 100, an address equal to `match_on_i` sets `tx_hold_o`. It stays set through data bytes and clears on the next address that differs from `match_on_i`.
- R5: In `flow_mode_i` 010, a character equal to `match_off_i` sets `tx_pause_o` and one equal to `match_on_i` clears it. Neither character is pushed.
- R6: While `half_duplex_i` = 1 and `tx_busy_i` = 1, line activity produces no character.
- R7: `status_o` bit 3 holds break, bit 4 framing, bit 5 parity and bit 6 overrun. These bits stay set until a cycle with `status_rd_i` = 1 clears them. Bits 2:0 read 0.
- R8: A low stop sample is a framing error and sets `push_tag_o` bit 1. A parity mismatch sets `push_tag_o` bit 0. The parity encodings are 001 odd, 010 even, 011 always 1 and 100 always 0. Parity is not checked in multidrop modes.
- R9: A character due for storage while `fifo_full_i` = 1 is dropped and sets the overrun flag.
- R10: A frame that is all zeros including the stop sample is a break. It is pushed once as 0x00 with `push_tag_o` bit 2. The receiver then waits for the line to go high, and `status_o` bit 7 is 1 only during that wait.
- R11: In 9-bit mode each stored character is pushed as two bytes on consecutive cycles: first the low 8 bits, then a byte holding data bit 8 in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial receive line |
| bit_div_i | input | DIV_W | Clocks per bit, at least 4 |
| fmt_len_i | input | 2 | Data length code |
| par_mode_i | input | 3 | Parity mode code |
| two_stop_i | input | 1 | Two stop bits |
| flow_mode_i | input | 3 | Flow/filter mode code |
| half_duplex_i | input | 1 | Ignore the line while transmitting |
| tx_busy_i | input | 1 | Local transmitter active |
| match_on_i | input | 8 | Resume / first address character |
| match_off_i | input | 8 | Pause / second address character |
| fifo_full_i | input | 1 | RX FIFO cannot accept a byte |
| push_o | output | 1 | Push strobe |
| push_data_o | output | 8 | Byte pushed |
| push_tag_o | output | 3 | {break, framing, parity} tag |
| rx_open_o | output | 1 | Multidrop receive gate open |
| tx_pause_o | output | 1 | Pause request to transmitter |
| tx_hold_o | output | 1 | Transmit-enable hold |
| status_rd_i | input | 1 | Status read, clears sticky bits |
| status_o | output | 8 | Error status |

## Verification
Several properties are checked on every cycle. No frame completes while half-duplex blocking is active. No second frame is reported while a break is still holding the line low. Address frames, frames arriving at a closed gate and frames arriving at a full FIFO never produce a push. A pause request rises only after a frame seen in software mode. Sticky status bits never drop without a read, and a read with no new event clears them all. Only the directed scenarios can show the rest: correct bit timing and character values, parity and framing tags across the format settings, glitch rejection, the two-byte push order, the open/close and hold sequences across address streams, and break reporting together with its live bit.

// File: rtl/mdrop_rx_pkg.sv
package mdrop_rx_pkg;
  localparam int SLOT_MAX = 9;

  typedef enum logic [2:0] {
    FLOW_NONE    = 3'b000,
    FLOW_HW      = 3'b001,
    FLOW_SW      = 3'b010,
    FLOW_MD_XCVR = 3'b011,
    FLOW_MD_TXEN = 3'b100
  } flow_e;

  typedef enum logic [1:0] {
    LEN7 = 2'b00,
    LEN8 = 2'b01,
    LEN9 = 2'b10
  } len_e;

  typedef enum logic [2:0] {
    PAR_NONE  = 3'b000,
    PAR_ODD   = 3'b001,
    PAR_EVEN  = 3'b010,
    PAR_MARK  = 3'b011,
    PAR_SPACE = 3'b100
  } par_e;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } tag_t;
endpackage

// File: rtl/mdrop_rx_sampler.sv
module mdrop_rx_sampler
  import mdrop_rx_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rxd_i,
  input  logic [DIV_W-1:0]    bit_div_i,
  input  logic [1:0]          fmt_len_i,
  input  logic                par_on_i,
  input  logic                two_stop_i,
  input  logic                hdx_block_i,
  output logic                frm_v_o,
  output logic [SLOT_MAX-1:0] frm_bits_o,
  output logic                frm_stop_err_o,
  output logic                frm_brk_o,
  output logic                brk_live_o
);
  localparam int SLOT_W = $clog2(SLOT_MAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_STOP, S_WAIT} st_e;

  st_e                 state_q;
  logic [1:0]          sync_q;
  logic                rx_s;
  logic [DIV_W-1:0]    cnt_q;
  logic [SLOT_W-1:0]   slot_q;
  logic [SLOT_W-1:0]   nslots;
  logic                stop_idx_q;
  logic                stop_low_q;
  logic [SLOT_MAX-1:0] bits_q;
  logic                stop_low_now;
  logic                brk_now;
  logic                last_stop;

  assign rx_s = sync_q[1];

  always_comb begin
    case (fmt_len_i)
      LEN7:    nslots = SLOT_W'(7) + SLOT_W'(par_on_i);
      LEN9:    nslots = SLOT_W'(9);
      default: nslots = SLOT_W'(8) + SLOT_W'(par_on_i);
    endcase
  end

  assign stop_low_now = stop_low_q | ~rx_s;
  assign brk_now      = (bits_q == '0) && stop_low_now;
  assign last_stop    = stop_idx_q | ~two_stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= S_IDLE;
      sync_q         <= 2'b11;
      cnt_q          <= '0;
      slot_q         <= '0;
      stop_idx_q     <= 1'b0;
      stop_low_q     <= 1'b0;
      bits_q         <= '0;
      frm_v_o        <= 1'b0;
      frm_stop_err_o <= 1'b0;
      frm_brk_o      <= 1'b0;
    end else begin
      sync_q  <= {sync_q[0], rxd_i};
      frm_v_o <= 1'b0;
      if (hdx_block_i && state_q != S_WAIT) begin
        state_q <= S_IDLE;
      end else begin
        case (state_q)
          S_IDLE: if (!rx_s) begin
            state_q    <= S_START;
            cnt_q      <= (bit_div_i >> 1) - 1'b1;
            bits_q     <= '0;
            slot_q     <= '0;
            stop_low_q <= 1'b0;
          end
          S_START: begin
            if (cnt_q == '0) begin
              if (rx_s) state_q <= S_IDLE;  // glitch
              else begin
                state_q <= S_DATA;
                cnt_q   <= bit_div_i - 1'b1;
              end
            end else cnt_q <= cnt_q - 1'b1;
          end
          S_DATA: begin
            if (cnt_q == '0) begin
              for (int i = 0; i < SLOT_MAX; i++)
                if (slot_q == SLOT_W'(i)) bits_q[i] <= rx_s;
              cnt_q <= bit_div_i - 1'b1;
              if (slot_q == nslots - 1'b1) begin
                state_q    <= S_STOP;
                stop_idx_q <= 1'b0;
              end else slot_q <= slot_q + 1'b1;
            end else cnt_q <= cnt_q - 1'b1;
          end
          S_STOP: begin
            if (cnt_q == '0) begin
              stop_low_q <= stop_low_now;
              if (last_stop) begin
                frm_v_o        <= 1'b1;
                frm_brk_o      <= brk_now;
                frm_stop_err_o <= stop_low_now & ~brk_now;
                state_q        <= brk_now ? S_WAIT : S_IDLE;
              end else begin
                stop_idx_q <= 1'b1;
                cnt_q      <= bit_div_i - 1'b1;
              end
            end else cnt_q <= cnt_q - 1'b1;
          end
          S_WAIT: if (rx_s) state_q <= S_IDLE;
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  assign frm_bits_o = bits_q;
  assign brk_live_o = (state_q == S_WAIT);

  AST_HDX_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdx_block_i |=> !frm_v_o); // R6
  AST_BRK_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_live_o && $past(brk_live_o)) |-> !frm_v_o); // R10
endmodule

// File: rtl/mdrop_rx_filter.sv
module mdrop_rx_filter
  import mdrop_rx_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                frm_v_i,
  input  logic [SLOT_MAX-1:0] frm_bits_i,
  input  logic                frm_stop_err_i,
  input  logic                frm_brk_i,
  input  logic [1:0]          fmt_len_i,
  input  logic [2:0]          par_mode_i,
  input  logic [2:0]          flow_mode_i,
  input  logic [7:0]          match_on_i,
  input  logic [7:0]          match_off_i,
  input  logic                fifo_full_i,
  output logic                push_o,
  output logic [7:0]          push_data_o,
  output logic [2:0]          push_tag_o,
  output logic                gate_o,
  output logic                tx_pause_o,
  output logic                tx_hold_o,
  output logic                ovr_ev_o,
  output logic                par_ev_o,
  output logic                frm_ev_o,
  output logic                brk_ev_o
);
  logic nine, len7, par_on, has_flag, flag, md, sw, txen;
  logic [7:0] chr;
  logic is_addr, par_bad, par_err, is_xoff, is_xon, store, want;
  logic gate_q, hold_q, pause_q, hi_pend_q, hi_bit_q;
  tag_t tag_now, tag_q;

  assign nine     = (fmt_len_i == LEN9);
  assign len7     = (fmt_len_i == LEN7);
  assign par_on   = (par_mode_i != PAR_NONE);
  assign has_flag = nine | par_on;
  assign flag     = len7 ? frm_bits_i[7] : frm_bits_i[8];
  assign chr      = len7 ? {1'b0, frm_bits_i[6:0]} : frm_bits_i[7:0];
  assign md       = (flow_mode_i == FLOW_MD_XCVR) || (flow_mode_i == FLOW_MD_TXEN);
  assign sw       = (flow_mode_i == FLOW_SW);
  assign txen     = (flow_mode_i == FLOW_MD_TXEN);
  assign is_addr  = md & has_flag & flag;

  always_comb begin
    case (par_mode_i)
      PAR_ODD:   par_bad = ~(^{chr, flag});
      PAR_EVEN:  par_bad = ^{chr, flag};
      PAR_MARK:  par_bad = ~flag;
      PAR_SPACE: par_bad = flag;
      default:   par_bad = 1'b0;
    endcase
  end

  assign par_err = ~md & ~nine & par_on & par_bad;
  assign is_xoff = sw & (chr == match_off_i);
  assign is_xon  = sw & (chr == match_on_i) & ~is_xoff;
  assign store   = ~is_addr & ~is_xoff & ~is_xon & (~md | gate_q);
  assign want    = frm_v_i & store;
  assign tag_now = '{brk: frm_brk_i, frm: frm_stop_err_i, par: par_err};

  assign ovr_ev_o = fifo_full_i & (want | hi_pend_q);
  assign par_ev_o = frm_v_i & par_err;
  assign frm_ev_o = frm_v_i & frm_stop_err_i;
  assign brk_ev_o = frm_v_i & frm_brk_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q      <= 1'b0;
      hold_q      <= 1'b0;
      pause_q     <= 1'b0;
      hi_pend_q   <= 1'b0;
      hi_bit_q    <= 1'b0;
      tag_q       <= '0;
      push_o      <= 1'b0;
      push_data_o <= '0;
      push_tag_o  <= '0;
    end else begin
      push_o    <= 1'b0;
      hi_pend_q <= 1'b0;
      if (hi_pend_q && !fifo_full_i) begin
        push_o      <= 1'b1;
        push_data_o <= {7'b0, hi_bit_q};
        push_tag_o  <= tag_q;
      end
      if (frm_v_i) begin
        if (is_addr) begin
          gate_q <= (chr == match_on_i) || (chr == match_off_i);
          if (txen) hold_q <= (chr == match_on_i);
        end
        if (is_xoff) pause_q <= 1'b1;
        if (is_xon)  pause_q <= 1'b0;
        if (want && !fifo_full_i) begin
          push_o      <= 1'b1;
          push_data_o <= chr;
          push_tag_o  <= tag_now;
          tag_q       <= tag_now;
          hi_pend_q   <= nine;
          hi_bit_q    <= frm_bits_i[8];
        end
      end
    end
  end

  assign gate_o     = gate_q;
  assign tx_hold_o  = hold_q & txen;
  assign tx_pause_o = pause_q & sw;

  AST_ADDR_NEVER_PUSHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_v_i && is_addr) |=> !push_o); // R3
  AST_CLOSED_NO_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_v_i && md && !gate_q && !is_addr) |=> !push_o); // R3
  AST_FULL_NO_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_v_i && fifo_full_i) |=> !push_o); // R9
  AST_PAUSE_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pause_q) |-> $past(frm_v_i && sw)); // R5
  AST_HI_BYTE_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && $past(push_o)) |-> (push_data_o[7:1] == 7'b0)); // R11
endmodule

// File: rtl/mdrop_rx_status.sv
module mdrop_rx_status (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       brk_ev_i,
  input  logic       frm_ev_i,
  input  logic       par_ev_i,
  input  logic       ovr_ev_i,
  input  logic       brk_live_i,
  input  logic       status_rd_i,
  output logic [7:0] status_o
);
  logic [3:0] sticky_q;
  logic [3:0] ev;

  assign ev = {ovr_ev_i, par_ev_i, frm_ev_i, brk_ev_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sticky_q <= '0;
    else         sticky_q <= (status_rd_i ? 4'b0 : sticky_q) | ev;
  end

  assign status_o = {brk_live_i, sticky_q, 3'b000};

  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_rd_i |=> ((status_o[6:3] & $past(status_o[6:3])) == $past(status_o[6:3]))); // R7
  AST_RD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_rd_i && ev == 4'b0) |=> (status_o[6:3] == 4'b0)); // R7
endmodule

// File: rtl/mdrop_uart_rx.sv
module mdrop_uart_rx
  import mdrop_rx_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rxd_i,
  input  logic [DIV_W-1:0] bit_div_i,
  input  logic [1:0]       fmt_len_i,
  input  logic [2:0]       par_mode_i,
  input  logic             two_stop_i,
  input  logic [2:0]       flow_mode_i,
  input  logic             half_duplex_i,
  input  logic             tx_busy_i,
  input  logic [7:0]       match_on_i,
  input  logic [7:0]       match_off_i,
  input  logic             fifo_full_i,
  output logic             push_o,
  output logic [7:0]       push_data_o,
  output logic [2:0]       push_tag_o,
  output logic             rx_open_o,
  output logic             tx_pause_o,
  output logic             tx_hold_o,
  input  logic             status_rd_i,
  output logic [7:0]       status_o
);
  logic                frm_v, frm_stop_err, frm_brk, brk_live;
  logic [SLOT_MAX-1:0] frm_bits;
  logic                ovr_ev, par_ev, frm_ev, brk_ev;
  logic                par_slot;

  assign par_slot = (par_mode_i != PAR_NONE) && (fmt_len_i != LEN9);

  mdrop_rx_sampler #(.DIV_W(DIV_W)) i_sampler (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .rxd_i          (rxd_i),
    .bit_div_i      (bit_div_i),
    .fmt_len_i      (fmt_len_i),
    .par_on_i       (par_slot),
    .two_stop_i     (two_stop_i),
    .hdx_block_i    (half_duplex_i & tx_busy_i),
    .frm_v_o        (frm_v),
    .frm_bits_o     (frm_bits),
    .frm_stop_err_o (frm_stop_err),
    .frm_brk_o      (frm_brk),
    .brk_live_o     (brk_live)
  );

  mdrop_rx_filter i_filter (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .frm_v_i        (frm_v),
    .frm_bits_i     (frm_bits),
    .frm_stop_err_i (frm_stop_err),
    .frm_brk_i      (frm_brk),
    .fmt_len_i      (fmt_len_i),
    .par_mode_i     (par_mode_i),
    .flow_mode_i    (flow_mode_i),
    .match_on_i     (match_on_i),
    .match_off_i    (match_off_i),
    .fifo_full_i    (fifo_full_i),
    .push_o         (push_o),
    .push_data_o    (push_data_o),
    .push_tag_o     (push_tag_o),
    .gate_o         (rx_open_o),
    .tx_pause_o     (tx_pause_o),
    .tx_hold_o      (tx_hold_o),
    .ovr_ev_o       (ovr_ev),
    .par_ev_o       (par_ev),
    .frm_ev_o       (frm_ev),
    .brk_ev_o       (brk_ev)
  );

  mdrop_rx_status i_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .brk_ev_i    (brk_ev),
    .frm_ev_i    (frm_ev),
    .par_ev_i    (par_ev),
    .ovr_ev_i    (ovr_ev),
    .brk_live_i  (brk_live),
    .status_rd_i (status_rd_i),
    .status_o    (status_o)
  );
endmodule

// File: tb/test_mdrop_uart_rx.sv
module test_mdrop_uart_rx;
  localparam int DIV = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rxd = 1'b1;
  logic [15:0] bit_div = 16'(DIV);
  logic [1:0]  fmt_len = 2'b01;
  logic [2:0]  par_mode = 3'b000;
  logic        two_stop = 1'b0;
  logic [2:0]  flow_mode = 3'b000;
  logic        hdx = 1'b0;
  logic        tx_busy = 1'b0;
  logic [7:0]  m_on = 8'h11;
  logic [7:0]  m_off = 8'h13;
  logic        full = 1'b0;
  logic        status_rd = 1'b0;
  logic        push;
  logic [7:0]  push_data;
  logic [2:0]  push_tag;
  logic        rx_open, tx_pause, tx_hold;
  logic [7:0]  status;

  int checks = 0;
  int errors = 0;
  int cap_n = 0;
  logic [7:0] cap_d [0:63];
  logic [2:0] cap_t [0:63];

  always #4 clk = ~clk;

  mdrop_uart_rx #(.DIV_W(16)) i_mdrop_uart_rx (
    .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd), .bit_div_i(bit_div),
    .fmt_len_i(fmt_len), .par_mode_i(par_mode), .two_stop_i(two_stop),
    .flow_mode_i(flow_mode), .half_duplex_i(hdx), .tx_busy_i(tx_busy),
    .match_on_i(m_on), .match_off_i(m_off), .fifo_full_i(full),
    .push_o(push), .push_data_o(push_data), .push_tag_o(push_tag),
    .rx_open_o(rx_open), .tx_pause_o(tx_pause), .tx_hold_o(tx_hold),
    .status_rd_i(status_rd), .status_o(status)
  );

  always @(negedge clk) begin
    if (push && cap_n < 64) begin
      cap_d[cap_n] = push_data;
      cap_t[cap_n] = push_tag;
      cap_n++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic hold_bit(input logic lvl);
    rxd = lvl;
    repeat (DIV) @(negedge clk);
  endtask

  // start, nd data bits LSB first, optional parity slot, stops
  task automatic send(input logic [8:0] v, input int nd, input logic has_p,
                      input logic p, input int nstop, input logic stop_lvl);
    hold_bit(1'b0);
    for (int i = 0; i < nd; i++) hold_bit(v[i]);
    if (has_p) hold_bit(p);
    for (int i = 0; i < nstop; i++) hold_bit(stop_lvl);
    rxd = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic send8(input logic [7:0] v);
    send({1'b0, v}, 8, 1'b0, 1'b0, 1, 1'b1);
  endtask

  task automatic send9(input logic [8:0] v);
    send(v, 9, 1'b0, 1'b0, 1, 1'b1);
  endtask

  task automatic read_status();
    status_rd = 1'b1;
    @(negedge clk);
    status_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R7 reset status", status, 0);
    check("R3 reset gate closed", rx_open, 0);
    check("R5 reset pause", tx_pause, 0);
    check("R4 reset hold", tx_hold, 0);
    check("R1 reset no push", cap_n, 0);
  endtask

  task automatic t_basic();
    cap_n = 0;
    send8(8'hA5);
    check("R1 8-bit count", cap_n, 1);
    check("R1 8-bit data", cap_d[0], 8'hA5);
    check("R1 8-bit tag", cap_t[0], 0);
    send8(8'h3C);
    check("R1 second char", cap_d[1], 8'h3C);
  endtask

  task automatic t_parity();
    fmt_len = 2'b00; par_mode = 3'b010; two_stop = 1'b1;
    cap_n = 0;
    send(9'h035, 7, 1'b1, 1'b0, 2, 1'b1);       // 0x35 has four ones: even p=0
    check("R8 even ok count", cap_n, 1);
    check("R8 even ok data", cap_d[0], 8'h35);
    check("R8 even ok tag", cap_t[0], 0);
    send(9'h035, 7, 1'b1, 1'b1, 2, 1'b1);
    check("R8 even bad tag", cap_t[1], 3'b001);
    check("R7 parity sticky", status, 8'h20);
    read_status();
    check("R7 read clears", status, 8'h00);
    par_mode = 3'b001;
    send(9'h035, 7, 1'b1, 1'b1, 2, 1'b1);
    check("R8 odd ok tag", cap_t[2], 0);
    par_mode = 3'b011;
    send(9'h035, 7, 1'b1, 1'b0, 2, 1'b1);
    check("R8 mark bad tag", cap_t[3], 3'b001);
    read_status();
    fmt_len = 2'b01; par_mode = 3'b000; two_stop = 1'b0;
  endtask

  task automatic t_framing();
    cap_n = 0;
    send({1'b0, 8'h81}, 8, 1'b0, 1'b0, 1, 1'b0);
    repeat (2 * DIV) @(negedge clk);
    check("R8 framing count", cap_n, 1);
    check("R8 framing tag", cap_t[0], 3'b010);
    check("R7 framing sticky", status, 8'h10);
    read_status();
  endtask

  task automatic t_break();
    cap_n = 0;
    rxd = 1'b0;
    repeat (15 * DIV) @(negedge clk);
    check("R10 live break", status[7], 1);
    check("R10 break pushed once", cap_n, 1);
    check("R10 break data", cap_d[0], 0);
    check("R10 break tag", cap_t[0], 3'b100);
    repeat (10 * DIV) @(negedge clk);
    check("R10 still once", cap_n, 1);
    rxd = 1'b1;
    repeat (2 * DIV) @(negedge clk);
    check("R10 live cleared, sticky kept", status, 8'h08);
    read_status();
  endtask

  task automatic t_glitch();
    cap_n = 0;
    rxd = 1'b0;
    repeat (3) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * DIV) @(negedge clk);
    check("R2 glitch no push", cap_n, 0);
    send8(8'h42);
    check("R2 normal after glitch", cap_d[0], 8'h42);
  endtask

  task automatic t_overrun();
    cap_n = 0;
    full = 1'b1;
    send8(8'h77);
    full = 1'b0;
    check("R9 dropped", cap_n, 0);
    check("R9 overrun sticky", status, 8'h40);
    read_status();
  endtask

  task automatic t_nine();
    fmt_len = 2'b10;
    cap_n = 0;
    send9(9'h13C);
    check("R11 two bytes", cap_n, 2);
    check("R11 low byte", cap_d[0], 8'h3C);
    check("R11 high byte", cap_d[1], 8'h01);
  endtask

  task automatic t_multidrop();
    fmt_len = 2'b10; flow_mode = 3'b011; m_on = 8'h41; m_off = 8'h42;
    cap_n = 0;
    send9(9'h055);
    check("R3 closed drops data", cap_n, 0);
    send9(9'h141);
    check("R3 address not stored", cap_n, 0);
    check("R3 match first opens", rx_open, 1);
    send9(9'h0AA);
    check("R3 open stores", cap_n, 2);
    check("R3 open data", cap_d[0], 8'hAA);
    check("R11 open high byte", cap_d[1], 8'h00);
    send9(9'h150);
    check("R3 mismatch closes", rx_open, 0);
    send9(9'h066);
    check("R3 closed again drops", cap_n, 2);
    send9(9'h142);
    check("R3 match second opens", rx_open, 1);
    send9(9'h033);
    check("R3 stored after second", cap_d[2], 8'h33);
    check("R4 no hold in 011", tx_hold, 0);
  endtask

  task automatic t_txen();
    flow_mode = 3'b100;
    cap_n = 0;
    send9(9'h141);
    check("R4 hold on first match", tx_hold, 1);
    send9(9'h077);
    check("R4 hold through data", tx_hold, 1);
    check("R4 data stored", cap_d[0], 8'h77);
    send9(9'h142);
    check("R4 hold drops on other addr", tx_hold, 0);
    check("R4 gate still open", rx_open, 1);
    send9(9'h155);
    check("R4 gate closes", rx_open, 0);
    check("R4 addresses not stored", cap_n, 2);
    flow_mode = 3'b000; fmt_len = 2'b01;
  endtask

  task automatic t_swflow();
    flow_mode = 3'b010; m_on = 8'h11; m_off = 8'h13;
    cap_n = 0;
    send8(8'h13);
    check("R5 pause set", tx_pause, 1);
    check("R5 pause char not stored", cap_n, 0);
    send8(8'h20);
    check("R5 data passes", cap_d[0], 8'h20);
    check("R5 pause held", tx_pause, 1);
    send8(8'h11);
    check("R5 resume", tx_pause, 0);
    check("R5 resume char not stored", cap_n, 1);
    flow_mode = 3'b000;
  endtask

  task automatic t_hdx();
    hdx = 1'b1; tx_busy = 1'b1;
    cap_n = 0;
    send8(8'h5A);
    check("R6 ignored while busy", cap_n, 0);
    tx_busy = 1'b0;
    send8(8'h5A);
    check("R6 received when idle", cap_n, 1);
    hdx = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_basic();
    t_parity();
    t_framing();
    t_break();
    t_glitch();
    t_overrun();
    t_nine();
    t_multidrop();
    t_txen();
    t_swflow();
    t_hdx();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule